// File: doc/BRIEF.md
# Byte-Laned Dual-Port Memory Port Controller

This block is a two-port word memory in which each port has its own full set of controls: a memory enable, a read/write select, an output gate, separate upper and lower byte-lane selects, and a semaphore select. Each cycle, every port's controls are decoded into one operation. The operation is a memory read, a write to one or both byte lanes, a semaphore access that is passed on to external semaphore logic, an idle deselect, or an illegal combination that is flagged. A write-inhibit input on each port lets an external busy arbiter block that port's writes while its reads carry on.

The model is synchronous, with one operation per port per clock edge. Read data, the per-lane valid flags, the error flag and the semaphore strobe all appear one cycle after the edge that samples the request. The storage is split into an upper and a lower lane, each holding `LANE_W` bits. The depth is 2^`ADDR_W` words; an `ADDR_W` of 14 gives the full 16K-word array. Both ports may touch any word in the same cycle.

Top module: `dpm_ctrl`

## Requirements
- R1: After reset, both ports show read data 0, both lane-valid flags low, the error flag low and the semaphore strobe low.
- R2: With the memory enable and the semaphore select both low, the port is idle: the next cycle shows no valid flag, read data 0 and no error, and no write takes place.
- R3: With the memory enable high, the semaphore select low and read/write low (write), only the selected lanes are written: the upper select covers bits 15:8 and the lower select covers bits 7:0.
- R4: With the memory enable high, the semaphore select low, read/write high and the output gate high, each selected lane returns its stored data one cycle later with its valid flag high; an unselected lane reads 0 with its flag low.
- R5: With both byte selects low, no lane is read or written.
- R6: With the output gate low, no lane-valid flag rises and the read data is 0, whatever the other inputs are.
- R7: Memory enable high, semaphore select high and any byte select high together raise the error flag one cycle later, and nothing is written.
- R8: Semaphore select high with either the memory enable low or both byte selects low pulses the semaphore strobe one cycle later, with no error, no memory write and no valid flag.
- R9: Data written through one port can be read through the other port from the next cycle on.
- R10: A read on one port in the same cycle as a write to that word from the other port returns the data held before the write.
- R11: With write-inhibit high, the port's writes are blocked, but its reads still return data.
- R12: When both ports write the same lane of the same word in the same cycle, port B's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| a_ce | input | 1 | Port A memory enable, active high |
| a_rnw | input | 1 | Port A read (1) / write (0) |
| a_oe | input | 1 | Port A output gate, active high |
| a_hi | input | 1 | Port A upper lane select |
| a_lo | input | 1 | Port A lower lane select |
| a_sem | input | 1 | Port A semaphore select |
| a_blk | input | 1 | Port A write-inhibit from the busy arbiter |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_rdata | output | 2*LANE_W | Port A read data, unselected lanes 0 |
| a_vld | output | 2 | Port A lane-valid flags, bit 1 upper, bit 0 lower |
| a_err | output | 1 | Port A illegal-combination flag |
| a_sem_go | output | 1 | Port A semaphore access strobe |
| b_ce | input | 1 | Port B memory enable |
| b_rnw | input | 1 | Port B read / write |
| b_oe | input | 1 | Port B output gate |
| b_hi | input | 1 | Port B upper lane select |
| b_lo | input | 1 | Port B lower lane select |
| b_sem | input | 1 | Port B semaphore select |
| b_blk | input | 1 | Port B write-inhibit |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_rdata | output | 2*LANE_W | Port B read data |
| b_vld | output | 2 | Port B lane-valid flags |
| b_err | output | 1 | Port B illegal-combination flag |
| b_sem_go | output | 1 | Port B semaphore strobe |

## Verification
Writes are tried with the upper lane alone, the lower lane alone and both lanes, each followed by a full read, so that a swapped or merged lane enable gives a wrong mixed word. Control patterns that should be inert are each followed by a read of the word they might have changed: idle, no byte select, output gate low, illegal, semaphore and inhibited. This separates a decode that suppresses only the output from one that also stops the write. The cross-port patterns cover a read on one port against a write on the other, both in the same cycle and one cycle later, and two writes colliding on one word. These separate old-data, new-data and write-priority behaviour.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
   localparam int unsigned NLANES = 2;   // index 1 = upper lane, 0 = lower lane

   typedef struct packed {
      logic [NLANES-1:0] wr;   // lane write enables
      logic [NLANES-1:0] rd;   // lane read enables
      logic              sem;  // semaphore access
      logic              err;  // forbidden combination
   } dpm_cmd_t;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
   import dpm_pkg::*;
(
   input  logic     ce,
   input  logic     rnw,
   input  logic     oe,
   input  logic     hi,
   input  logic     lo,
   input  logic     sem,
   input  logic     blk,
   output dpm_cmd_t cmd
);
   logic [NLANES-1:0] lane_sel;
   logic              mem_ok;
   logic              any_lane;

   always_comb begin
      lane_sel = {hi, lo};
      any_lane = |lane_sel;
      mem_ok   = ce & ~sem;
      cmd.err  = ce & sem & any_lane;
      cmd.sem  = sem & (~ce | ~any_lane);
      cmd.wr   = (mem_ok & ~rnw & ~blk) ? lane_sel : '0;
      cmd.rd   = (mem_ok & rnw & oe)    ? lane_sel : '0;
   end
endmodule

// File: rtl/dpm_lane_ram.sv
module dpm_lane_ram #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              we_a,
   input  logic [ADDR_W-1:0] ad_a,
   input  logic [LANE_W-1:0] wd_a,
   output logic [LANE_W-1:0] q_a,
   input  logic              we_b,
   input  logic [ADDR_W-1:0] ad_b,
   input  logic [LANE_W-1:0] wd_b,
   output logic [LANE_W-1:0] q_b
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   // Reads see the contents before this edge's writes; port B writes last.
   always_ff @(posedge clk) begin
      q_a <= mem[ad_a];
      q_b <= mem[ad_b];
      if (we_a) mem[ad_a] <= wd_a;
      if (we_b) mem[ad_b] <= wd_b;
   end
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
   import dpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                a_ce,
   input  logic                a_rnw,
   input  logic                a_oe,
   input  logic                a_hi,
   input  logic                a_lo,
   input  logic                a_sem,
   input  logic                a_blk,
   input  logic [ADDR_W-1:0]   a_addr,
   input  logic [2*LANE_W-1:0] a_wdata,
   output logic [2*LANE_W-1:0] a_rdata,
   output logic [1:0]          a_vld,
   output logic                a_err,
   output logic                a_sem_go,
   input  logic                b_ce,
   input  logic                b_rnw,
   input  logic                b_oe,
   input  logic                b_hi,
   input  logic                b_lo,
   input  logic                b_sem,
   input  logic                b_blk,
   input  logic [ADDR_W-1:0]   b_addr,
   input  logic [2*LANE_W-1:0] b_wdata,
   output logic [2*LANE_W-1:0] b_rdata,
   output logic [1:0]          b_vld,
   output logic                b_err,
   output logic                b_sem_go
);
   localparam int unsigned NP     = 2;
   localparam int unsigned DATA_W = NLANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr
      $error("dpm_ctrl: ADDR_W must be in 1..14");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("dpm_ctrl: LANE_W must be positive");
   end

   logic [NP-1:0]             p_ce, p_rnw, p_oe, p_hi, p_lo, p_sem, p_blk;
   logic [ADDR_W-1:0]         p_addr [NP];
   logic [DATA_W-1:0]         p_wd   [NP];
   logic [DATA_W-1:0]         p_rd   [NP];
   logic [NLANES-1:0]         vld_q  [NP];
   logic [NP-1:0]             err_q, sem_q;
   dpm_cmd_t                  cmd    [NP];
   logic [LANE_W-1:0]         lane_q [NP][NLANES];

   always_comb begin
      p_ce  = {b_ce,  a_ce};
      p_rnw = {b_rnw, a_rnw};
      p_oe  = {b_oe,  a_oe};
      p_hi  = {b_hi,  a_hi};
      p_lo  = {b_lo,  a_lo};
      p_sem = {b_sem, a_sem};
      p_blk = {b_blk, a_blk};
      p_addr[0] = a_addr;  p_addr[1] = b_addr;
      p_wd[0]   = a_wdata; p_wd[1]   = b_wdata;
   end

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      dpm_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
         .clk  (clk),
         .we_a (cmd[0].wr[l]),
         .ad_a (p_addr[0]),
         .wd_a (p_wd[0][l*LANE_W +: LANE_W]),
         .q_a  (lane_q[0][l]),
         .we_b (cmd[1].wr[l]),
         .ad_b (p_addr[1]),
         .wd_b (p_wd[1][l*LANE_W +: LANE_W]),
         .q_b  (lane_q[1][l])
      );
   end

   for (genvar p = 0; p < NP; p++) begin : g_port
      dpm_port_decode u_dec (
         .ce  (p_ce[p]),
         .rnw (p_rnw[p]),
         .oe  (p_oe[p]),
         .hi  (p_hi[p]),
         .lo  (p_lo[p]),
         .sem (p_sem[p]),
         .blk (p_blk[p]),
         .cmd (cmd[p])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[p] <= '0;
            err_q[p] <= 1'b0;
            sem_q[p] <= 1'b0;
         end else begin
            vld_q[p] <= cmd[p].rd;
            err_q[p] <= cmd[p].err;
            sem_q[p] <= cmd[p].sem;
         end
      end

      for (genvar l = 0; l < NLANES; l++) begin : g_mux
         assign p_rd[p][l*LANE_W +: LANE_W] = vld_q[p][l] ? lane_q[p][l] : '0;
      end

      // R2: an idle port is quiet on the next cycle
      p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!p_ce[p] && !p_sem[p]) |=> (vld_q[p] == '0 && p_rd[p] == '0 && !err_q[p]));
      // R6: output gate low never yields valid data
      p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !p_oe[p] |=> (vld_q[p] == '0 && p_rd[p] == '0));
      // R7: forbidden combination is flagged
      p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (p_ce[p] && p_sem[p] && (p_hi[p] || p_lo[p])) |=> err_q[p]);
      // R8: semaphore strobe never coincides with error or data
      p_sem_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
         sem_q[p] |-> (!err_q[p] && vld_q[p] == '0));
      // R11: inhibited read still returns the upper lane
      p_inhibit_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (p_ce[p] && !p_sem[p] && p_rnw[p] && p_oe[p] && p_blk[p] && p_hi[p]) |=> vld_q[p][1]);
   end

   assign a_rdata  = p_rd[0];
   assign a_vld    = vld_q[0];
   assign a_err    = err_q[0];
   assign a_sem_go = sem_q[0];
   assign b_rdata  = p_rd[1];
   assign b_vld    = vld_q[1];
   assign b_err    = err_q[1];
   assign b_sem_go = sem_q[1];
endmodule

// File: tb/tb_dpm_ctrl.sv
module tb_dpm_ctrl;
   localparam int AW = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic a_ce = 0, a_rnw = 1, a_oe = 0, a_hi = 0, a_lo = 0, a_sem = 0, a_blk = 0;
   logic b_ce = 0, b_rnw = 1, b_oe = 0, b_hi = 0, b_lo = 0, b_sem = 0, b_blk = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [15:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
   logic [1:0] a_vld, b_vld;
   logic a_err, a_sem_go, b_err, b_sem_go;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dpm_ctrl #(.ADDR_W(AW), .LANE_W(8)) dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bits: ce rnw oe hi lo sem blk
   task automatic drv_a(logic [6:0] c, logic [AW-1:0] ad, logic [15:0] wd);
      {a_ce, a_rnw, a_oe, a_hi, a_lo, a_sem, a_blk} = c; a_addr = ad; a_wdata = wd;
   endtask
   task automatic drv_b(logic [6:0] c, logic [AW-1:0] ad, logic [15:0] wd);
      {b_ce, b_rnw, b_oe, b_hi, b_lo, b_sem, b_blk} = c; b_addr = ad; b_wdata = wd;
   endtask
   task automatic idle();
      drv_a(7'b0100000, '0, '0); drv_b(7'b0100000, '0, '0);
   endtask
   task automatic step(); @(negedge clk); endtask
   task automatic rd_a(logic [AW-1:0] ad, string req, logic [15:0] exp);
      drv_a(7'b1111100, ad, '0); step(); chk(req, a_rdata, exp); idle();
   endtask

   task automatic t_reset();
      chk("R1 rdata", {a_rdata, b_rdata}, '0);
      chk("R1 flags", {a_vld, b_vld, a_err, b_err, a_sem_go, b_sem_go}, '0);
   endtask

   task automatic t_lanes();
      drv_a(7'b1011100, 6, 16'h1234); step(); idle();
      rd_a(6, "R3 full write", 16'h1234);
      drv_a(7'b1011000, 6, 16'hABCD); step(); idle();
      rd_a(6, "R3 upper only", 16'hAB34);
      drv_a(7'b1010100, 6, 16'hFF77); step(); idle();
      rd_a(6, "R3 lower only", 16'hAB77);
      drv_a(7'b1111000, 6, '0); step();
      chk("R4 upper read", {a_vld, a_rdata}, {2'b10, 16'hAB00}); idle();
   endtask

   task automatic t_inert();
      drv_a(7'b1010000, 6, 16'hFFFF); step();
      chk("R5 no select flags", a_vld, 2'b00); idle();
      drv_a(7'b1110000, 6, '0); step();
      chk("R5 no select read", a_vld, 2'b00); idle();
      rd_a(6, "R5 no write", 16'hAB77);
      drv_a(7'b1101100, 6, '0); step();
      chk("R6 gate off", {a_vld, a_rdata}, '0); idle();
      drv_a(7'b0011100, 6, 16'h0000); step();
      chk("R2 idle outputs", {a_vld, a_rdata, a_err}, '0); idle();
      rd_a(6, "R2 no write", 16'hAB77);
      drv_a(7'b1011110, 6, 16'h0000); step();
      chk("R7 error flag", {a_err, a_sem_go}, 2'b10); idle();
      rd_a(6, "R7 no write", 16'hAB77);
      drv_a(7'b0011110, 6, 16'h0000); step();
      chk("R8 sem strobe", {a_sem_go, a_err, a_vld}, 4'b1000); idle();
      drv_a(7'b1100010, 6, '0); step();
      chk("R8 sem no lanes", {a_sem_go, a_err}, 2'b10); idle();
      rd_a(6, "R8 no write", 16'hAB77);
   endtask

   task automatic t_cross();
      drv_a(7'b1011100, 9, 16'h1111); step(); idle();
      drv_b(7'b1111100, 9, '0); step();
      chk("R9 cross read", b_rdata, 16'h1111); idle();
      drv_a(7'b1011100, 9, 16'h2222); drv_b(7'b1111100, 9, '0); step();
      chk("R10 old data", b_rdata, 16'h1111); idle();
      drv_b(7'b1111100, 9, '0); step();
      chk("R10 new data after", b_rdata, 16'h2222); idle();
      drv_b(7'b1011101, 9, 16'h3333); step(); idle();
      rd_a(9, "R11 write blocked", 16'h2222);
      drv_b(7'b1111101, 9, '0); step();
      chk("R11 read allowed", {b_vld, b_rdata}, {2'b11, 16'h2222}); idle();
      drv_a(7'b1011100, 10, 16'h4444); drv_b(7'b1011100, 10, 16'h5555); step(); idle();
      rd_a(10, "R12 B wins", 16'h5555);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1; step();
      t_lanes();
      t_inert();
      t_cross();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule